// File: doc/BRIEF.md
# Receive Frame Queue with Acknowledge-Driven Advance

This block holds received CAN frames for a host processor until the host services them, in the order they arrived. Each entry is a full record: identifier, extended-format flag, remote-request flag, length code and an eight-byte payload. The oldest pending entry is always presented on one fixed set of head outputs. The host never moves a pointer. It reads the head and then acknowledges the frame-available interrupt, and that acknowledge removes the head entry and brings the next one forward.

Frames come in from an acceptance filter as a one-cycle write strobe with the record alongside it. The block keeps a level frame-available interrupt and a sticky warning flag that sets when the queue reaches a partial-fill level. It also keeps a sticky overflow flag that sets when a frame arrives while every slot is occupied. A frame that arrives into a full queue is dropped, and no frame is taken in until the host frees a slot. The warning and overflow flags each have their own clear strobe.

Top module: `rxq_frame_fifo`

## Requirements
- R1: After reset, fill_count is 0 and frame_avail, warn_flag and ovf_flag are all low.
- R2: Frames leave in arrival order. While frame_avail is high, the head outputs show the oldest pending frame: head_id, head_ext, head_rtr, head_len and head_data exactly as written.
- R3: frame_avail is high exactly when fill_count is non-zero. It changes on the clock edge that registers the write or acknowledge.
- R4: An avail_clr pulse while a frame is pending removes the head. From the next cycle the head outputs show the following frame, and frame_avail stays high if any frame remains.
- R5: The queue stores up to DEPTH frames (default 6). A write strobe into a non-full queue is accepted and raises fill_count by one on the next edge.
- R6: A write strobe while fill_count equals DEPTH and no acknowledge is in the same cycle drops the frame. fill_count and the queued contents, including the head, are unchanged.
- R7: ovf_flag sets on the edge after a dropped write and stays set until an ovf_clr pulse. If a drop and ovf_clr occur in the same cycle, the flag stays set.
- R8: warn_flag sets on the edge where fill_count goes from below WARN_LEVEL (default 4) to WARN_LEVEL or above. It stays set until a warn_clr pulse, and a new set event in the same cycle as the clear wins.
- R9: A write strobe and an acknowledge in the same cycle with at least one frame pending are both applied, and fill_count is unchanged. This holds also when the queue is full, in which case the new frame is accepted and no overflow is flagged.
- R10: An avail_clr pulse while the queue is empty is ignored. fill_count stays 0, frame_avail stays low, and the next written frame appears at the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | One-cycle strobe: a filtered frame is offered |
| wr_id | input | 29 | Identifier of the offered frame |
| wr_ext | input | 1 | Offered frame uses the extended identifier format |
| wr_rtr | input | 1 | Offered frame is a remote request |
| wr_len | input | 4 | Data length code of the offered frame |
| wr_data | input | 64 | Payload of the offered frame |
| avail_clr | input | 1 | Host acknowledge of frame-available; pops the head |
| warn_clr | input | 1 | Clears the sticky warning flag |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| head_id | output | 29 | Identifier of the oldest pending frame |
| head_ext | output | 1 | Extended-format flag of the head frame |
| head_rtr | output | 1 | Remote-request flag of the head frame |
| head_len | output | 4 | Length code of the head frame |
| head_data | output | 64 | Payload of the head frame |
| frame_avail | output | 1 | Frame-available interrupt, level |
| warn_flag | output | 1 | Sticky partial-fill warning |
| ovf_flag | output | 1 | Sticky overflow indication |
| fill_count | output | 3 | Number of frames pending |

## Verification
The bench builds the block with its defaults: six slots and a warning level of four. At these values a short burst of writes fills the queue and reaches the drop path. The read and write indices also wrap around the six-slot ring many times over a few thousand cycles. Writes are issued at a higher rate than acknowledges, so the random stream sits at full often. That hits acknowledge-and-write at full, drops while a clear is pending, and repeated crossings of the warning level after a clear.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    parameter int ID_W   = 29;
    parameter int LEN_W  = 4;
    parameter int DATA_W = 64;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic              ext;
        logic              rtr;
        logic [LEN_W-1:0]  len;
        logic [DATA_W-1:0] data;
    } frame_t;

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_ptr,
    input  frame_t           wr_frame,
    input  logic [PTR_W-1:0] rd_ptr,
    output frame_t           rd_frame
);

    frame_t slot_d [DEPTH];
    frame_t slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_comb begin
            slot_d[g] = slot_q[g];
            if (wr_en && (wr_ptr == PTR_W'(g))) begin
                slot_d[g] = wr_frame;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else begin
                slot_q[g] <= slot_d[g];
            end
        end
    end

    always_comb begin
        rd_frame = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_ptr == PTR_W'(i)) begin
                rd_frame = slot_q[i];
            end
        end
    end

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
    parameter int DEPTH = 6,
    parameter int PTR_W = 3,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic             pop_req,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_d,
    output logic             drop_evt
);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  pop_ok, full, accept;

    function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d     = st_q;
        full     = (st_q.cnt == CNT_W'(DEPTH));
        pop_ok   = pop_req && (st_q.cnt != '0);
        accept   = push_req && (!full || pop_ok);
        drop_evt = push_req && full && !pop_ok;
        if (accept) begin
            st_d.wr = adv(st_q.wr);
        end
        if (pop_ok) begin
            st_d.rd = adv(st_q.rd);
        end
        case ({accept, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en  = accept;
    assign wr_ptr = st_q.wr;
    assign rd_ptr = st_q.rd;
    assign cnt_q  = st_q.cnt;
    assign cnt_d  = st_d.cnt;

    // R5
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));

    // R6
    drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !pop_req && cnt_q == CNT_W'(DEPTH))
        |=> ($stable(wr_ptr) && $stable(rd_ptr) && cnt_q == CNT_W'(DEPTH)));

    // R9
    push_pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pop_req && cnt_q != '0) |=> $stable(cnt_q));

    // R10
    empty_pop_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push_req && cnt_q == '0) |=> (cnt_q == '0 && $stable(rd_ptr)));

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags #(
    parameter int CNT_W      = 3,
    parameter int WARN_LEVEL = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] cnt_d,
    input  logic             drop_evt,
    input  logic             warn_clr,
    input  logic             ovf_clr,
    output logic             avail,
    output logic             warn,
    output logic             ovf
);

    typedef struct packed {
        logic avail;
        logic warn;
        logic ovf;
    } flag_t;

    flag_t fl_d, fl_q;
    logic  warn_set;

    always_comb begin
        fl_d       = fl_q;
        warn_set   = (cnt_q < CNT_W'(WARN_LEVEL)) && (cnt_d >= CNT_W'(WARN_LEVEL));
        fl_d.avail = (cnt_d != '0);
        if (warn_set) begin
            fl_d.warn = 1'b1;
        end else if (warn_clr) begin
            fl_d.warn = 1'b0;
        end
        if (drop_evt) begin
            fl_d.ovf = 1'b1;
        end else if (ovf_clr) begin
            fl_d.ovf = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign avail = fl_q.avail;
    assign warn  = fl_q.warn;
    assign ovf   = fl_q.ovf;

    // R3
    avail_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        avail == (cnt_q != '0));

    // R7
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_evt |=> ovf);

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);

    // R8
    warn_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warn && !warn_clr) |=> warn);

endmodule

// File: rtl/rxq_frame_fifo.sv
module rxq_frame_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH      = 6,
    parameter int WARN_LEVEL = 4,
    localparam int PTR_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ID_W-1:0]   wr_id,
    input  logic              wr_ext,
    input  logic              wr_rtr,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              avail_clr,
    input  logic              warn_clr,
    input  logic              ovf_clr,
    output logic [ID_W-1:0]   head_id,
    output logic              head_ext,
    output logic              head_rtr,
    output logic [LEN_W-1:0]  head_len,
    output logic [DATA_W-1:0] head_data,
    output logic              frame_avail,
    output logic              warn_flag,
    output logic              ovf_flag,
    output logic [CNT_W-1:0]  fill_count
);

    frame_t           in_frame, head_frame;
    logic             wr_en, drop_evt;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        in_frame.id   = wr_id;
        in_frame.ext  = wr_ext;
        in_frame.rtr  = wr_rtr;
        in_frame.len  = wr_len;
        in_frame.data = wr_data;
    end

    rxq_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (wr_valid),
        .pop_req  (avail_clr),
        .wr_en    (wr_en),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .cnt_q    (cnt_q),
        .cnt_d    (cnt_d),
        .drop_evt (drop_evt)
    );

    rxq_store #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_ptr   (wr_ptr),
        .wr_frame (in_frame),
        .rd_ptr   (rd_ptr),
        .rd_frame (head_frame)
    );

    rxq_flags #(.CNT_W(CNT_W), .WARN_LEVEL(WARN_LEVEL)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_q    (cnt_q),
        .cnt_d    (cnt_d),
        .drop_evt (drop_evt),
        .warn_clr (warn_clr),
        .ovf_clr  (ovf_clr),
        .avail    (frame_avail),
        .warn     (warn_flag),
        .ovf      (ovf_flag)
    );

    assign head_id    = head_frame.id;
    assign head_ext   = head_frame.ext;
    assign head_rtr   = head_frame.rtr;
    assign head_len   = head_frame.len;
    assign head_data  = head_frame.data;
    assign fill_count = cnt_q;

    // R4
    pop_advances_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (avail_clr && !wr_valid && cnt_q != '0) |=> (fill_count == $past(cnt_q) - 1'b1));

endmodule

// File: tb/rxq_frame_fifo_test.sv
module rxq_frame_fifo_test;

    localparam int FR_W = 29 + 1 + 1 + 4 + 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [28:0] wr_id = '0;
    logic        wr_ext = 1'b0;
    logic        wr_rtr = 1'b0;
    logic [3:0]  wr_len = '0;
    logic [63:0] wr_data = '0;
    logic        avail_clr = 1'b0;
    logic        warn_clr = 1'b0;
    logic        ovf_clr = 1'b0;
    logic [28:0] head_id;
    logic        head_ext, head_rtr;
    logic [3:0]  head_len;
    logic [63:0] head_data;
    logic        frame_avail, warn_flag, ovf_flag;
    logic [2:0]  fill_count;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [FR_W-1:0] mq[$];
    logic            e_warn = 1'b0;
    logic            e_ovf = 1'b0;

    rxq_frame_fifo uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_id(wr_id),
        .wr_ext(wr_ext), .wr_rtr(wr_rtr), .wr_len(wr_len), .wr_data(wr_data),
        .avail_clr(avail_clr), .warn_clr(warn_clr), .ovf_clr(ovf_clr),
        .head_id(head_id), .head_ext(head_ext), .head_rtr(head_rtr),
        .head_len(head_len), .head_data(head_data), .frame_avail(frame_avail),
        .warn_flag(warn_flag), .ovf_flag(ovf_flag), .fill_count(fill_count)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [FR_W-1:0] rnd_frame();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    // Full comparison of every output against the model
    task automatic compare_all();
        chk("R5 fill_count", 128'(fill_count), 128'(mq.size()));
        chk("R3 frame_avail", 128'(frame_avail), 128'(mq.size() != 0));
        chk("R8 warn_flag", 128'(warn_flag), 128'(e_warn));
        chk("R7 ovf_flag", 128'(ovf_flag), 128'(e_ovf));
        if (mq.size() != 0) begin
            chk("R2 head frame", 128'({head_id, head_ext, head_rtr, head_len, head_data}),
                128'(mq[0]));
        end
    endtask

    // One cycle: drive after the falling edge, update the model, sample after the rising edge
    task automatic step(input bit wv, input logic [FR_W-1:0] fr, input bit ac,
                        input bit wc, input bit oc);
        bit pop, full, acc, drop, wset;
        int prev;
        @(negedge clk);
        wr_valid  = wv;
        {wr_id, wr_ext, wr_rtr, wr_len, wr_data} = fr;
        avail_clr = ac;
        warn_clr  = wc;
        ovf_clr   = oc;
        prev = mq.size();
        pop  = ac && (prev != 0);
        full = (prev == 6);
        acc  = wv && (!full || pop);
        drop = wv && full && !pop;
        if (pop) void'(mq.pop_front());
        if (acc) mq.push_back(fr);
        wset = (prev < 4) && (mq.size() >= 4);
        if (wset) e_warn = 1'b1; else if (wc) e_warn = 1'b0;
        if (drop) e_ovf = 1'b1; else if (oc) e_ovf = 1'b0;
        @(posedge clk);
        #2;
        wr_valid = 1'b0; avail_clr = 1'b0; warn_clr = 1'b0; ovf_clr = 1'b0;
        compare_all();
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [FR_W-1:0] f0, keep;
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 fill_count", 128'(fill_count), 128'(0));
        chk("R1 frame_avail", 128'(frame_avail), 128'(0));
        chk("R1 warn_flag", 128'(warn_flag), 128'(0));
        chk("R1 ovf_flag", 128'(ovf_flag), 128'(0));

        // R10 acknowledge while empty is ignored, then a write lands at the head
        step(0, '0, 1, 0, 0);
        chk("R10 empty pop count", 128'(fill_count), 128'(0));
        f0 = rnd_frame();
        step(1, f0, 0, 0, 0);
        chk("R10 head after empty pop", 128'({head_id, head_ext, head_rtr, head_len, head_data}),
            128'(f0));

        // R5 fill to capacity; R8 warning at the fourth frame
        for (int i = 0; i < 5; i++) step(1, rnd_frame(), 0, 0, 0);
        chk("R5 full count", 128'(fill_count), 128'(6));
        chk("R8 warn at level", 128'(warn_flag), 128'(1));

        // R6 write into full queue is dropped
        keep = mq[0];
        step(1, rnd_frame(), 0, 0, 0);
        chk("R6 count after drop", 128'(fill_count), 128'(6));
        chk("R6 head after drop", 128'({head_id, head_ext, head_rtr, head_len, head_data}),
            128'(keep));
        chk("R7 ovf set", 128'(ovf_flag), 128'(1));

        // R7 drop with clear in same cycle keeps the flag set
        step(1, rnd_frame(), 0, 0, 1);
        chk("R7 set beats clear", 128'(ovf_flag), 128'(1));
        step(0, '0, 0, 0, 1);
        chk("R7 cleared", 128'(ovf_flag), 128'(0));

        // R9 write and acknowledge together at full
        step(1, rnd_frame(), 1, 0, 0);
        chk("R9 count unchanged at full", 128'(fill_count), 128'(6));
        chk("R9 no overflow", 128'(ovf_flag), 128'(0));

        // R8 clear while still above the level stays clear
        step(0, '0, 0, 1, 0);
        chk("R8 cleared", 128'(warn_flag), 128'(0));

        // R4 drain in order
        for (int i = 0; i < 6; i++) begin
            step(0, '0, 1, 0, 0);
            chk("R4 avail while remaining", 128'(frame_avail), 128'(mq.size() != 0));
        end
        chk("R4 drained", 128'(fill_count), 128'(0));

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            step(($urandom() % 100) < 55, rnd_frame(), ($urandom() % 100) < 40,
                 ($urandom() % 100) < 8, ($urandom() % 100) < 8);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule